// File: doc/BRIEF.md
# LCD Controller Host Command Port

This block is the microcontroller-facing port of a dot-matrix LCD column driver. The host talks to it over an 8-bit parallel bus with chip-select, read, write and a register-select line. A write with register-select high stores a 4-bit command code. A write with register-select low carries a byte. The byte is either handed to one of eight configuration registers that sit elsewhere in the driver, or it is stored in display RAM at the cursor address. The port does not hold the configuration registers, the RAM or the cursor counters itself. For each executed byte it raises one load strobe or one RAM strobe for a single cycle, and it raises a cursor-step strobe whenever RAM is touched.

After every executed data access the port is busy for a fixed number of clock cycles (`BUSY_CYCLES`). The host polls this with a status read, which returns the busy flag on bit 7. RAM reads go through a one-stage output register. A read returns what the previous fetch captured and then starts a new fetch, so the first read after the cursor moves is a dummy.

Busy state machine: `BZ_IDLE` moves to `BZ_EXEC` on an executed data access (the START transition) and loads a countdown of `BUSY_CYCLES-1`. `BZ_EXEC` counts down and returns to `BZ_IDLE` on the cycle after the count reaches zero (the EXPIRE transition). The decode step classifies each accepted data access as one of four actions: `ACT_NONE`, `ACT_CFG`, `ACT_RAMWR` or `ACT_RAMRD`.

Top module: `lcd_host_port`

## Requirements
- R1: After reset, busy reads 0, every strobe output is 0, the command code is 0h, and the data output register holds 00h.
- R2: A write with `bus_rs`=1 while not busy stores `bus_din[3:0]` as the command code. Bits 7..4 are ignored. It raises no strobe and leaves busy at 0.
- R3: A write with `bus_rs`=0 while not busy, with a code of 0h, 1h, 2h, 3h, 8h, 9h, Ah or Bh, raises `cfg_load` bit 0, 1, 2, 3, 4, 5, 6 or 7 respectively. The bit is high for exactly the one cycle after the write edge, and `cfg_data` then equals the written byte.
- R4: A data write with code Eh raises `ram_we` and `cur_step` together for the one cycle after the write edge, with `ram_wdata` equal to the byte.
- R5: An executed data access (any data write, or a data read with code Fh) makes busy read 1 for exactly `BUSY_CYCLES` cycles (4 by default), starting the cycle after the access edge. Busy then returns to 0.
- R6: A read with `bus_rs`=1 returns busy on bit 7 and zeros on bits 6..0, whatever the code is. It changes no state.
- R7: A write of either kind that arrives while busy is 1 is dropped. It changes neither the code nor the strobes, and it does not lengthen the busy period.
- R8: A data read with code Fh while not busy drives the data output register onto `bus_dout`. In the next cycle it raises `ram_re` and `cur_step`. At the end of that cycle it captures `ram_rdata` into the register, so each read returns the byte fetched by the previous read.
- R9: A data write with any code other than the ten listed (4h–7h, Ch, Dh) raises no strobe, but busy still runs as in R5.
- R10: A data read while busy, or with a code other than Fh, returns the data output register. It fetches nothing, does not step the cursor and does not set busy.
- R11: `bus_dout` is 00h whenever `bus_cs` and `bus_rd` are not both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_rs | input | 1 | 1 = command/status, 0 = data |
| bus_din | input | 8 | Write data from host |
| bus_dout | output | 8 | Read data to host |
| cfg_load | output | 8 | One-hot load strobe for the configuration registers |
| cfg_data | output | 8 | Byte for the configuration register being loaded |
| ram_we | output | 1 | Display RAM write strobe |
| ram_wdata | output | 8 | Display RAM write byte |
| ram_re | output | 1 | Display RAM fetch strobe |
| ram_rdata | input | 8 | Display RAM byte at the cursor address |
| cur_step | output | 1 | Cursor decrement strobe |

## Verification
On every cycle, the assertions check these properties:
- busy rises only after an executed access and never falls while the countdown is non-zero;
- at most one of the load and RAM strobes is high at a time, and a load pulse never lasts two cycles;
- a RAM strobe always comes with a cursor step, and a fetch always coincides with busy;
- the command code and the data output register change only when they are written;
- writes that arrive while busy produce no strobe.

Only the bench scenarios can show the end-to-end behaviour. These scenarios cover:
- the exact busy length for every code;
- the code-to-strobe mapping;
- the stale first read after a cursor move;
- the cursor advancing exactly once per fetch (using a small RAM and cursor model in the bench);
- a written byte coming back through the read pipeline.

// File: rtl/lcd_hp_pkg.sv
package lcd_hp_pkg;

    localparam int CFG_N = 8;

    localparam logic [3:0] OP_MODE    = 4'h0;
    localparam logic [3:0] OP_PITCH   = 4'h1;
    localparam logic [3:0] OP_COUNT   = 4'h2;
    localparam logic [3:0] OP_DIV     = 4'h3;
    localparam logic [3:0] OP_START1  = 4'h8;
    localparam logic [3:0] OP_START2  = 4'h9;
    localparam logic [3:0] OP_CUR_LO  = 4'hA;
    localparam logic [3:0] OP_CUR_HI  = 4'hB;
    localparam logic [3:0] OP_RAM_WR  = 4'hE;
    localparam logic [3:0] OP_RAM_RD  = 4'hF;

    typedef enum logic {
        BZ_IDLE,
        BZ_EXEC
    } busy_st_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_CFG,
        ACT_RAMWR,
        ACT_RAMRD
    } act_e;

    // one-hot configuration strobe for a command code, zero when not a config code
    function automatic logic [CFG_N-1:0] cfg_onehot(input logic [3:0] code);
        logic [CFG_N-1:0] v;
        v = '0;
        unique case (code)
            OP_MODE:   v[0] = 1'b1;
            OP_PITCH:  v[1] = 1'b1;
            OP_COUNT:  v[2] = 1'b1;
            OP_DIV:    v[3] = 1'b1;
            OP_START1: v[4] = 1'b1;
            OP_START2: v[5] = 1'b1;
            OP_CUR_LO: v[6] = 1'b1;
            OP_CUR_HI: v[7] = 1'b1;
            default:   v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/lcd_hp_busy.sv
module lcd_hp_busy
    import lcd_hp_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);

    busy_st_e          st, st_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= BZ_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            BZ_IDLE: begin
                if (start) begin
                    st_nx  = BZ_EXEC;
                    cnt_nx = CNT_W'(BUSY_CYCLES - 1);
                end
            end
            BZ_EXEC: begin
                if (cnt == '0) begin
                    st_nx = BZ_IDLE;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            default: st_nx = BZ_IDLE;
        endcase
    end

    always_comb begin
        busy = (st == BZ_EXEC);
    end

    // R5: an executed access while idle raises busy on the next cycle
    p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R5: busy cannot appear without a start
    p_busy_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !busy) |=> !busy);

    // R5: busy holds while the countdown is not exhausted
    p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> busy);

endmodule

// File: rtl/lcd_hp_decode.sv
module lcd_hp_decode
    import lcd_hp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_we,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [DATA_W-1:0] din,
    output logic              exec_go,
    output logic [CFG_N-1:0]  cfg_load,
    output logic [DATA_W-1:0] wr_byte,
    output logic              ram_we,
    output logic              ram_re,
    output logic              cur_step
);

    logic [CODE_W-1:0] ir_code;
    act_e              act_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_code <= '0;
        end else if (ir_we) begin
            ir_code <= din[CODE_W-1:0];
        end
    end

    always_comb begin
        act_nx = ACT_NONE;
        if (data_we) begin
            if (cfg_onehot(4'(ir_code)) != '0) begin
                act_nx = ACT_CFG;
            end else if (4'(ir_code) == OP_RAM_WR) begin
                act_nx = ACT_RAMWR;
            end
        end else if (data_re && 4'(ir_code) == OP_RAM_RD) begin
            act_nx = ACT_RAMRD;
        end
    end

    always_comb begin
        exec_go = data_we || (act_nx == ACT_RAMRD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_load <= '0;
            wr_byte  <= '0;
            ram_we   <= 1'b0;
            ram_re   <= 1'b0;
            cur_step <= 1'b0;
        end else begin
            cfg_load <= (act_nx == ACT_CFG) ? cfg_onehot(4'(ir_code)) : '0;
            ram_we   <= (act_nx == ACT_RAMWR);
            ram_re   <= (act_nx == ACT_RAMRD);
            cur_step <= (act_nx == ACT_RAMWR) || (act_nx == ACT_RAMRD);
            if (data_we) begin
                wr_byte <= din;
            end
        end
    end

    // R3: at most one destination strobe per cycle
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_load, ram_we, ram_re}));

    // R4 / R8: every RAM access steps the cursor
    p_ram_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |-> cur_step);

    // R2: command code only changes on a command write
    p_ir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_we |=> $stable(ir_code));

endmodule

// File: rtl/lcd_hp_rdpipe.sv
module lcd_hp_rdpipe #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] dout_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (capture) begin
            dout_q <= ram_rdata;
        end
    end

    // R8 / R10: output register only changes on a fetch
    p_dout_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(dout_q));

endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port
    import lcd_hp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CODE_W      = 4,
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_rs,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic [CFG_N-1:0]  cfg_load,
    output logic [DATA_W-1:0] cfg_data,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_re,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              cur_step
);

    logic              busy;
    logic              wr_ok;
    logic              ir_we;
    logic              data_we;
    logic              data_re;
    logic              exec_go;
    logic [DATA_W-1:0] wr_byte;
    logic [DATA_W-1:0] dout_q;

    always_comb begin
        wr_ok   = bus_cs && bus_wr && !busy;
        ir_we   = wr_ok && bus_rs;
        data_we = wr_ok && !bus_rs;
        data_re = bus_cs && bus_rd && !bus_wr && !bus_rs && !busy;
    end

    lcd_hp_decode #(
        .DATA_W (DATA_W),
        .CODE_W (CODE_W)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ir_we    (ir_we),
        .data_we  (data_we),
        .data_re  (data_re),
        .din      (bus_din),
        .exec_go  (exec_go),
        .cfg_load (cfg_load),
        .wr_byte  (wr_byte),
        .ram_we   (ram_we),
        .ram_re   (ram_re),
        .cur_step (cur_step)
    );

    lcd_hp_busy #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (exec_go),
        .busy  (busy)
    );

    lcd_hp_rdpipe #(
        .DATA_W (DATA_W)
    ) u_rdpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (ram_re),
        .ram_rdata (ram_rdata),
        .dout_q    (dout_q)
    );

    always_comb begin
        cfg_data  = wr_byte;
        ram_wdata = wr_byte;
        bus_dout  = '0;
        if (bus_cs && bus_rd) begin
            bus_dout = bus_rs ? {busy, {(DATA_W-1){1'b0}}} : dout_q;
        end
    end

    // R7: writes during busy never produce a strobe
    p_busy_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_cs && bus_wr) |=> (cfg_load == '0 && !ram_we));

    // R3: a configuration load lasts a single cycle
    p_load_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load != '0) |=> (cfg_load == '0));

    // R8: a fetch always coincides with the busy period it started
    p_fetch_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |-> busy);

endmodule

// File: tb/lcd_host_port_tb.sv
`timescale 1ns/1ps
module lcd_host_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, bus_rs = 1'b0;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout;
    logic [7:0] cfg_load, cfg_data, ram_wdata, ram_rdata;
    logic       ram_we, ram_re, cur_step;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    lcd_host_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_rs(bus_rs), .bus_din(bus_din), .bus_dout(bus_dout),
        .cfg_load(cfg_load), .cfg_data(cfg_data), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_re(ram_re), .ram_rdata(ram_rdata),
        .cur_step(cur_step)
    );

    // small display RAM and cursor model outside the port
    logic [7:0] mem [16];
    logic [3:0] cur = 4'h0;
    assign ram_rdata = mem[cur];
    initial for (int i = 0; i < 16; i++) mem[i] = 8'h30 + 8'(i);
    always @(posedge clk) begin
        if (ram_we) mem[cur] <= ram_wdata;
        if (cfg_load[6]) cur <= cfg_data[3:0];
        else if (cur_step) cur <= cur - 4'h1;
    end

    // {code, data, expected cfg_load, expected ram_we}
    localparam int VEC_N = 13;
    localparam logic [20:0] VEC [VEC_N] = '{
        {4'h0, 8'h0F, 8'h01, 1'b0},
        {4'h1, 8'h07, 8'h02, 1'b0},
        {4'h2, 8'h0A, 8'h04, 1'b0},
        {4'h3, 8'h40, 8'h08, 1'b0},
        {4'h8, 8'h12, 8'h10, 1'b0},
        {4'h9, 8'h34, 8'h20, 1'b0},
        {4'hA, 8'h07, 8'h40, 1'b0},
        {4'hB, 8'h3F, 8'h80, 1'b0},
        {4'hE, 8'h5A, 8'h00, 1'b1},
        {4'h4, 8'hC3, 8'h00, 1'b0},
        {4'h7, 8'h99, 8'h00, 1'b0},
        {4'hC, 8'h55, 8'h00, 1'b0},
        {4'hD, 8'hAA, 8'h00, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic rs, input logic [7:0] d);
        bus_cs = 1'b1; bus_wr = 1'b1; bus_rs = rs; bus_din = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic peek_busy(input logic exp, input string req);
        bus_cs = 1'b1; bus_rd = 1'b1; bus_rs = 1'b1;
        #0.5;
        chk(req, 32'(bus_dout[7]), 32'(exp));
        chk("R6 status low bits", 32'(bus_dout[6:0]), 32'h0);
        bus_cs = 1'b0; bus_rd = 1'b0; bus_rs = 1'b0;
        #0.5;
        chk("R11 idle bus", 32'(bus_dout), 32'h0);
    endtask

    task automatic rd(output logic [7:0] v);
        bus_cs = 1'b1; bus_rd = 1'b1; bus_rs = 1'b0;
        #0.5;
        v = bus_dout;
        @(negedge clk);
        bus_cs = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL R5 watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 cfg_load", 32'(cfg_load), 32'h0);
        chk("R1 ram_we", 32'(ram_we), 32'h0);
        chk("R1 ram_re", 32'(ram_re), 32'h0);
        chk("R1 cur_step", 32'(cur_step), 32'h0);
        chk("R11 bus_dout idle", 32'(bus_dout), 32'h0);
        peek_busy(1'b0, "R1 busy");

        // table walk: R2 R3 R4 R5 R9
        for (int i = 0; i < VEC_N; i++) begin
            logic [3:0] code; logic [7:0] dat, eld; logic ewe;
            {code, dat, eld, ewe} = VEC[i];
            wr(1'b1, {4'h5, code});
            chk("R2 no strobe on code write", 32'({cfg_load, ram_we, ram_re}), 32'h0);
            peek_busy(1'b0, "R2 busy unchanged");
            wr(1'b0, dat);
            chk("R3/R9 cfg_load", 32'(cfg_load), 32'(eld));
            if (eld != 8'h00) chk("R3 cfg_data", 32'(cfg_data), 32'(dat));
            chk("R4 ram_we", 32'(ram_we), 32'(ewe));
            chk("R4 cur_step", 32'(cur_step), 32'(ewe));
            if (ewe) chk("R4 ram_wdata", 32'(ram_wdata), 32'(dat));
            for (int c = 0; c < 4; c++) begin
                peek_busy(1'b1, "R5 busy high");
                tick();
            end
            chk("R3 single pulse", 32'(cfg_load), 32'h0);
            peek_busy(1'b0, "R5 busy cleared");
        end

        // R8 read pipeline and dummy read
        wr(1'b1, 8'h0A); wr(1'b0, 8'h05); repeat (4) tick();
        wr(1'b1, 8'h0F);
        rd(v);
        chk("R8 first read stale (R1 reset value)", 32'(v), 32'h00);
        chk("R8 ram_re", 32'(ram_re), 32'h1);
        chk("R8 cur_step", 32'(cur_step), 32'h1);
        peek_busy(1'b1, "R5 busy after read");
        repeat (4) tick();
        rd(v); chk("R8 second read", 32'(v), 32'h35); repeat (4) tick();
        rd(v); chk("R8 third read", 32'(v), 32'h34);

        // R10 read while busy: no fetch
        tick();
        rd(v);
        chk("R10 busy read value", 32'(v), 32'h33);
        chk("R10 no fetch", 32'(ram_re), 32'h0);
        chk("R10 no step", 32'(cur_step), 32'h0);
        repeat (2) tick();
        rd(v); chk("R10 value after busy read", 32'(v), 32'h33); repeat (4) tick();
        rd(v); chk("R10 cursor stepped once", 32'(v), 32'h32); repeat (4) tick();

        // R4 written byte returns through the pipeline
        wr(1'b1, 8'h0A); wr(1'b0, 8'h07); repeat (4) tick();
        wr(1'b1, 8'h0F);
        rd(v); chk("R8 dummy after cursor move", 32'(v), 32'h31); repeat (4) tick();
        rd(v); chk("R4 readback", 32'(v), 32'h5A); repeat (4) tick();

        // R10 data read with a non-read code
        wr(1'b1, 8'h00);
        rd(v);
        chk("R10 other code value", 32'(v), 32'h36);
        chk("R10 other code no fetch", 32'(ram_re), 32'h0);
        peek_busy(1'b0, "R10 no busy");

        // R7 writes during busy are dropped
        wr(1'b0, 8'h11);
        chk("R7 first load", 32'(cfg_load), 32'h01);
        wr(1'b1, 8'h03);
        chk("R7 code write dropped", 32'(cfg_load), 32'h0);
        wr(1'b0, 8'h22);
        chk("R7 data write dropped", 32'({cfg_load, ram_we}), 32'h0);
        tick();
        peek_busy(1'b1, "R7 busy still high");
        tick();
        peek_busy(1'b0, "R7 busy not extended");
        wr(1'b0, 8'h33);
        chk("R7 code kept", 32'(cfg_load), 32'h01);
        chk("R7 data", 32'(cfg_data), 32'h33);
        repeat (4) tick();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule